// File: doc/BRIEF.md
# Tracked Register-Write Command Handler

This block is one stage of a command processor. It takes a stream of 32-bit packet words, groups them three at a time into a register-write command (a control word carrying three tracker flags, a target address, and a data value), and carries out the write on a register-write bus. Each tracker flag adds an optional side behaviour. The shadow flag holds writes to a small set of tracked control registers in local copies. Those copies go out only when a draw is signalled, and only if their value differs from what the hardware was last given. The render flag watches the render-control register. It requests a wait-for-idle ahead of a write that turns binning off, when the most recent draw ran with binning on while the pipeline was in bypass mode. The event flag emits a fixed event code when the data's lowest bit is clear.

Every output channel uses a valid/ready handshake. When one packet needs several actions, they go out one at a time in a fixed order. A draw strobe can arrive at any time. It is recorded, and the flush of the tracked copies runs at the next packet boundary, before the next packet is taken in.

Top module: `regwr_tracker`

## Requirements
- R1: A command is exactly three accepted words in this order: control word, address (low ADDR_W bits used), data. `pkt_ready` is high only while words are being collected, and never while an output action or a flush is in progress.
- R2: Only bits 2:0 of the control word are decoded. Bit 0 is the shadow flag, bit 1 is the render flag and bit 2 is the event flag. Every other bit has no effect, and any combination of the three flags is legal.
- R3: A write that is not deferred appears on the write bus (`wr_valid` high, with the packet's address and data) in the cycle right after the data word is accepted, unless a wait-for-idle comes first.
- R4: With the shadow flag set and the address matching one of the tracked addresses (defaults 0x0300, 0x0301, 0x0302), the write is held in a local copy and nothing goes on the write bus. With the shadow flag set and any other address, the write goes out at once.
- R5: On a draw, tracked entries holding a deferred value are visited in index order. An entry is written out only if its value differs from the last value written to that address on the bus, by either path. Equal values are dropped. Either way the entry stops being pending.
- R6: After reset no tracked address has a known hardware value, so the first deferred value for each one is written at the next draw, even when it is zero.
- R7: With the render flag set, an address equal to RENDER_ADDR (default 0x0100), binning bit BIN_BIT (default 2) of the new data clear, and the last draw having seen binning on in bypass mode, a wait-for-idle request precedes the write. If any of these conditions fails, no request is made.
- R8: At each draw strobe, the block records the binning bit of the value last written to RENDER_ADDR (0 after reset) and the level of `bypass_mode`. These stay unchanged until the next draw.
- R9: With the event flag set and data bit 0 clear, an event with code EVT_CODE (default 0x3F) is emitted for any address, including a deferred one. It is not emitted when data bit 0 is set.
- R10: The actions of one packet go out in the order wait-for-idle, write, event, with at most one valid at a time. Each valid, together with its payload, is held until its ready is seen.
- R11: A draw strobe seen while a packet is in progress is held. The flush runs as soon as that packet's actions finish, and `pkt_ready` stays low until the flush is done.
- R12: After reset `pkt_ready` is high and `wfi_valid`, `wr_valid` and `evt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet word valid |
| pkt_word | input | 32 | Packet word |
| pkt_ready | output | 1 | Packet word accepted when high with valid |
| draw_strobe | input | 1 | One-cycle draw indication |
| bypass_mode | input | 1 | Pipeline currently in bypass mode |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | 32 | Register write data |
| wr_ready | input | 1 | Register write accepted |
| wfi_valid | output | 1 | Wait-for-idle request |
| wfi_ready | input | 1 | Wait-for-idle acknowledged |
| evt_valid | output | 1 | Event write request |
| evt_code | output | 8 | Event code |
| evt_ready | input | 1 | Event write accepted |

## Verification
The table-driven walk sends control words with no flag, with flags surrounded by junk high bits, and with the event flag combined with odd and even data. This separates decoding of bits 2:0 from decoding of the whole word, and the data-bit test from the flag test. Directed sequences store equal and different values into tracked entries and then draw. These show whether the comparison is made against the last bus value or the reset value, and whether a direct write to a tracked address counts. The render cases change one hazard condition at a time (flag, data bit, recorded binning, recorded bypass), so that a wait-for-idle triggered by any single condition on its own is seen as a failure. A stalled ready and a draw arriving in the middle of a packet check ordering and deferral of the flush.

// File: rtl/regwr_pkg.sv
package regwr_pkg;

    localparam int FLG_SHADOW = 0;
    localparam int FLG_RENDER = 1;
    localparam int FLG_EVENT  = 2;
    localparam int FLG_W      = 3;

    typedef enum logic [2:0] {
        ST_W0   = 3'd0,
        ST_W1   = 3'd1,
        ST_W2   = 3'd2,
        ST_WFI  = 3'd3,
        ST_WR   = 3'd4,
        ST_EVT  = 3'd5,
        ST_FCHK = 3'd6,
        ST_FWR  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/regwr_decode.sv
module regwr_decode
    import regwr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NTRK = 3,
    parameter logic [NTRK*ADDR_W-1:0] TRK_ADDR_LIST = {16'h0302, 16'h0301, 16'h0300},
    parameter logic [ADDR_W-1:0] RENDER_ADDR = 16'h0100,
    localparam int IDX_W = (NTRK > 1) ? $clog2(NTRK) : 1
) (
    input  logic [FLG_W-1:0]  flags,
    input  logic [ADDR_W-1:0] addr,
    input  logic              data_lsb,
    input  logic              data_bin,
    input  logic              hazard_armed,
    output logic              defer,
    output logic [IDX_W-1:0]  trk_idx,
    output logic              need_wfi,
    output logic              need_evt
);

    logic [NTRK-1:0] match;
    logic            any_match;

    for (genvar gi = 0; gi < NTRK; gi++) begin : g_match
        assign match[gi] = (addr == TRK_ADDR_LIST[gi*ADDR_W +: ADDR_W]);
    end

    always_comb begin
        trk_idx = '0;
        for (int i = NTRK - 1; i >= 0; i--) begin
            if (match[i]) trk_idx = IDX_W'(i);
        end
    end

    assign any_match = |match;
    assign defer     = flags[FLG_SHADOW] && any_match;
    assign need_wfi  = flags[FLG_RENDER] && (addr == RENDER_ADDR) && !data_bin && hazard_armed;
    assign need_evt  = flags[FLG_EVENT] && !data_lsb;

endmodule

// File: rtl/regwr_bintrack.sv
module regwr_bintrack #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RENDER_ADDR = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_fire,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic              obs_bin,
    input  logic              draw,
    input  logic              bypass,
    output logic              hazard_armed
);

    typedef struct packed {
        logic ren_bin;
        logic last_bin;
        logic last_byp;
    } bt_t;

    bt_t q, n;

    always_comb begin
        n = q;
        if (draw) begin
            n.last_bin = q.ren_bin;
            n.last_byp = bypass;
        end
        if (obs_fire && (obs_addr == RENDER_ADDR)) begin
            n.ren_bin = obs_bin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign hazard_armed = q.last_bin && q.last_byp;

    AST_ARM_NEEDS_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hazard_armed) |-> $past(draw)); // R8

endmodule

// File: rtl/regwr_shadow.sv
module regwr_shadow #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 32,
    parameter int NTRK = 3,
    parameter logic [NTRK*ADDR_W-1:0] TRK_ADDR_LIST = {16'h0302, 16'h0301, 16'h0300},
    localparam int IDX_W = (NTRK > 1) ? $clog2(NTRK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_en,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [WORD_W-1:0] st_data,
    input  logic              obs_fire,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [WORD_W-1:0] obs_data,
    input  logic [IDX_W-1:0]  q_idx,
    output logic              q_pend,
    output logic              q_dirty,
    output logic [WORD_W-1:0] q_data,
    output logic [ADDR_W-1:0] q_addr,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);

    typedef struct packed {
        logic [NTRK-1:0]             pend;
        logic [NTRK-1:0]             hwv;
        logic [NTRK-1:0][WORD_W-1:0] shv;
        logic [NTRK-1:0][WORD_W-1:0] hwd;
    } sh_t;

    sh_t q, n;
    logic [NTRK-1:0] obs_hit;
    logic [NTRK-1:0] clr_hit;

    for (genvar gi = 0; gi < NTRK; gi++) begin : g_obs
        assign obs_hit[gi] = obs_fire && (obs_addr == TRK_ADDR_LIST[gi*ADDR_W +: ADDR_W]);
        assign clr_hit[gi] = clr_en && (clr_idx == IDX_W'(gi));
    end

    always_comb begin
        n = q;
        for (int i = 0; i < NTRK; i++) begin
            if (obs_hit[i]) begin
                n.hwv[i] = 1'b1;
                n.hwd[i] = obs_data;
            end
            if (clr_hit[i]) n.pend[i] = 1'b0;
            if (st_en && (st_idx == IDX_W'(i))) begin
                n.shv[i]  = st_data;
                n.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        q_pend  = 1'b0;
        q_dirty = 1'b0;
        q_data  = '0;
        q_addr  = '0;
        for (int i = 0; i < NTRK; i++) begin
            if (q_idx == IDX_W'(i)) begin
                q_pend  = q.pend[i];
                q_dirty = !q.hwv[i] || (q.hwd[i] != q.shv[i]);
                q_data  = q.shv[i];
                q_addr  = TRK_ADDR_LIST[i*ADDR_W +: ADDR_W];
            end
        end
    end

    AST_CLR_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> ((clr_hit & q.pend) != '0)); // R5

endmodule

// File: rtl/regwr_tracker.sv
module regwr_tracker
    import regwr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 32,
    parameter int NTRK = 3,
    parameter logic [NTRK*ADDR_W-1:0] TRK_ADDR_LIST = {16'h0302, 16'h0301, 16'h0300},
    parameter logic [ADDR_W-1:0] RENDER_ADDR = 16'h0100,
    parameter int BIN_BIT = 2,
    parameter int EVT_W = 8,
    parameter logic [EVT_W-1:0] EVT_CODE = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [WORD_W-1:0] pkt_word,
    output logic              pkt_ready,
    input  logic              draw_strobe,
    input  logic              bypass_mode,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              wfi_valid,
    input  logic              wfi_ready,
    output logic              evt_valid,
    output logic [EVT_W-1:0]  evt_code,
    input  logic              evt_ready
);

    localparam int IDX_W = (NTRK > 1) ? $clog2(NTRK) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NTRK - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [FLG_W-1:0]  flg;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              evt;
        logic              defer;
        logic              fpend;
        logic [IDX_W-1:0]  fidx;
    } ctl_t;

    ctl_t q, n;

    logic              acc;
    logic              obs_fire;
    logic              armed;
    logic              dec_defer, dec_wfi, dec_evt;
    logic [IDX_W-1:0]  dec_idx;
    logic              st_en;
    logic              clr_en;
    logic              sh_pend, sh_dirty;
    logic [WORD_W-1:0] sh_data;
    logic [ADDR_W-1:0] sh_addr;

    regwr_decode #(
        .ADDR_W(ADDR_W), .NTRK(NTRK),
        .TRK_ADDR_LIST(TRK_ADDR_LIST), .RENDER_ADDR(RENDER_ADDR)
    ) i_decode (
        .flags(q.flg), .addr(q.addr),
        .data_lsb(pkt_word[0]), .data_bin(pkt_word[BIN_BIT]),
        .hazard_armed(armed),
        .defer(dec_defer), .trk_idx(dec_idx),
        .need_wfi(dec_wfi), .need_evt(dec_evt)
    );

    regwr_shadow #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NTRK(NTRK), .TRK_ADDR_LIST(TRK_ADDR_LIST)
    ) i_shadow (
        .clk(clk), .rst_n(rst_n),
        .st_en(st_en), .st_idx(dec_idx), .st_data(pkt_word),
        .obs_fire(obs_fire), .obs_addr(wr_addr), .obs_data(wr_data),
        .q_idx(q.fidx), .q_pend(sh_pend), .q_dirty(sh_dirty),
        .q_data(sh_data), .q_addr(sh_addr),
        .clr_en(clr_en), .clr_idx(q.fidx)
    );

    regwr_bintrack #(
        .ADDR_W(ADDR_W), .RENDER_ADDR(RENDER_ADDR)
    ) i_bintrack (
        .clk(clk), .rst_n(rst_n),
        .obs_fire(obs_fire), .obs_addr(wr_addr), .obs_bin(wr_data[BIN_BIT]),
        .draw(draw_strobe), .bypass(bypass_mode),
        .hazard_armed(armed)
    );

    assign pkt_ready = ((q.st == ST_W0) && !q.fpend) || (q.st == ST_W1) || (q.st == ST_W2);
    assign acc       = pkt_valid && pkt_ready;
    assign wr_valid  = (q.st == ST_WR) || (q.st == ST_FWR);
    assign wr_addr   = (q.st == ST_FWR) ? sh_addr : q.addr;
    assign wr_data   = (q.st == ST_FWR) ? sh_data : q.data;
    assign wfi_valid = (q.st == ST_WFI);
    assign evt_valid = (q.st == ST_EVT);
    assign evt_code  = EVT_CODE;
    assign obs_fire  = wr_valid && wr_ready;

    always_comb begin
        n      = q;
        st_en  = 1'b0;
        clr_en = 1'b0;
        unique case (q.st)
            ST_W0: begin
                if (q.fpend) begin
                    n.fpend = 1'b0;
                    n.fidx  = '0;
                    n.st    = ST_FCHK;
                end else if (acc) begin
                    n.flg = pkt_word[FLG_W-1:0];
                    n.st  = ST_W1;
                end
            end
            ST_W1: begin
                if (acc) begin
                    n.addr = pkt_word[ADDR_W-1:0];
                    n.st   = ST_W2;
                end
            end
            ST_W2: begin
                if (acc) begin
                    n.data  = pkt_word;
                    n.evt   = dec_evt;
                    n.defer = dec_defer;
                    st_en   = dec_defer;
                    if (dec_wfi)         n.st = ST_WFI;
                    else if (!dec_defer) n.st = ST_WR;
                    else if (dec_evt)    n.st = ST_EVT;
                    else                 n.st = ST_W0;
                end
            end
            ST_WFI: begin
                if (wfi_ready) begin
                    if (!q.defer)   n.st = ST_WR;
                    else if (q.evt) n.st = ST_EVT;
                    else            n.st = ST_W0;
                end
            end
            ST_WR: begin
                if (wr_ready) n.st = q.evt ? ST_EVT : ST_W0;
            end
            ST_EVT: begin
                if (evt_ready) n.st = ST_W0;
            end
            ST_FCHK: begin
                if (sh_pend && sh_dirty) begin
                    n.st = ST_FWR;
                end else begin
                    clr_en = sh_pend;
                    if (q.fidx == LAST_IDX) n.st = ST_W0;
                    else                    n.fidx = q.fidx + 1'b1;
                end
            end
            ST_FWR: begin
                if (wr_ready) begin
                    clr_en = 1'b1;
                    if (q.fidx == LAST_IDX) begin
                        n.st = ST_W0;
                    end else begin
                        n.fidx = q.fidx + 1'b1;
                        n.st   = ST_FCHK;
                    end
                end
            end
            default: n.st = ST_W0;
        endcase
        if (draw_strobe) n.fpend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_W0;
        end else begin
            q <= n;
        end
    end

    AST_SINGLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wfi_valid, wr_valid, evt_valid})); // R10
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R10
    AST_WFI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wfi_valid && !wfi_ready |=> wfi_valid); // R10
    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ready |=> evt_valid); // R10
    AST_WFI_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wfi_valid && wfi_ready |=> wr_valid && (wr_addr == RENDER_ADDR)); // R7
    AST_NO_INTAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> !(wfi_valid || wr_valid || evt_valid)); // R1

endmodule

// File: tb/test_regwr_tracker.sv
module test_regwr_tracker;

    localparam logic [15:0] RENDER = 16'h0100;
    localparam int NV = 7;
    localparam logic [82:0] VEC [NV] = '{
        {32'h0000_0000, 16'h0040, 32'h0000_1234, 3'b010},
        {32'hFFFF_FFF8, 16'h0041, 32'h0000_0005, 3'b010},
        {32'h0000_0004, 16'h0042, 32'h0000_0010, 3'b011},
        {32'h0000_0004, 16'h0043, 32'h0000_0011, 3'b010},
        {32'h0000_0001, 16'h0044, 32'h0000_0007, 3'b010},
        {32'h0000_0002, RENDER,   32'h0000_0000, 3'b010},
        {32'hFFFF_FFF7, 16'h0045, 32'h0000_0002, 3'b011}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0;
    logic [31:0] pkt_word = '0;
    logic pkt_ready;
    logic draw_strobe = 1'b0;
    logic bypass_mode = 1'b0;
    logic wr_valid, wfi_valid, evt_valid;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [7:0] evt_code;
    logic wr_ready = 1'b1, wfi_ready = 1'b1, evt_ready = 1'b1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int log_n = 0;
    int log_kind [64];
    logic [15:0] log_addr [64];
    logic [31:0] log_data [64];
    int log_base = 0;
    int exp_n = 0;
    int exp_kind [8];
    logic [15:0] exp_addr [8];
    logic [31:0] exp_data [8];
    logic [2:0] first;

    always #2 clk = ~clk;

    regwr_tracker i_regwr_tracker (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_word(pkt_word), .pkt_ready(pkt_ready),
        .draw_strobe(draw_strobe), .bypass_mode(bypass_mode),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .wfi_valid(wfi_valid), .wfi_ready(wfi_ready),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_ready(evt_ready)
    );

    always @(negedge clk) begin
        if (wfi_valid && wfi_ready) begin
            log_kind[log_n % 64] = 1; log_addr[log_n % 64] = '0; log_data[log_n % 64] = '0;
            log_n = log_n + 1;
        end
        if (wr_valid && wr_ready) begin
            log_kind[log_n % 64] = 2; log_addr[log_n % 64] = wr_addr; log_data[log_n % 64] = wr_data;
            log_n = log_n + 1;
        end
        if (evt_valid && evt_ready) begin
            log_kind[log_n % 64] = 3; log_addr[log_n % 64] = '0;
            log_data[log_n % 64] = {24'h0, evt_code};
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic mark();
        @(posedge clk); #1;
        log_base = log_n;
        exp_n = 0;
    endtask

    task automatic push(input int k, input logic [15:0] a, input logic [31:0] d);
        exp_kind[exp_n] = k; exp_addr[exp_n] = a; exp_data[exp_n] = d;
        exp_n++;
    endtask

    task automatic verify(input string req);
        repeat (14) @(negedge clk);
        #1;
        chk((log_n - log_base) == exp_n, req, 64'(log_n - log_base), 64'(exp_n));
        if ((log_n - log_base) == exp_n) begin
            for (int i = 0; i < exp_n; i++) begin
                int j;
                j = (log_base + i) % 64;
                chk(log_kind[j] == exp_kind[i] && log_addr[j] == exp_addr[i] && log_data[j] == exp_data[i],
                    req, {8'(log_kind[j]), 8'h0, log_addr[j], log_data[j]},
                    {8'(exp_kind[i]), 8'h0, exp_addr[i], exp_data[i]});
            end
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        pkt_valid = 1'b1;
        pkt_word = w;
        while (!pkt_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_pkt(input logic [31:0] w0, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        send_word(w0);
        send_word(a);
        send_word(d);
        pkt_valid = 1'b0;
        first = {wfi_valid, wr_valid, evt_valid};
    endtask

    task automatic draw();
        @(negedge clk); draw_strobe = 1'b1;
        @(negedge clk); draw_strobe = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(pkt_ready && !wr_valid && !wfi_valid && !evt_valid, "R12",
            {60'h0, pkt_ready, wr_valid, wfi_valid, evt_valid}, 64'h8);

        // Table walk: R1 framing, R2 high bits, R3 timing, R4 untracked, R9 event
        for (int v = 0; v < NV; v++) begin
            logic [31:0] w0, dd;
            logic [15:0] aa;
            logic [2:0] ex;
            {w0, aa, dd, ex} = VEC[v];
            mark();
            send_pkt(w0, {16'h0, aa}, dd);
            // R3: first action visible right after the data word
            chk(first == (ex[2] ? 3'b100 : 3'b010), "R3", 64'(first), ex[2] ? 64'h4 : 64'h2);
            if (ex[2]) push(1, '0, '0);
            if (ex[1]) push(2, aa, dd);
            if (ex[0]) push(3, '0, 32'h3F);
            verify(v == 1 || v == 6 ? "R2" : (v == 2 || v == 3) ? "R9" : v == 4 ? "R4" : "R1");
        end

        // R4 deferred write, then R6 first value written even if zero
        mark();
        send_pkt(32'h1, 32'h0300, 32'h0);
        chk(first == 3'b000, "R4", 64'(first), 64'h0);
        verify("R4");
        mark();
        draw();
        chk(!pkt_ready, "R11", 64'(pkt_ready), 64'h0);
        push(2, 16'h0300, 32'h0);
        verify("R6");

        // R5 equal dropped, different written in index order
        mark();
        send_pkt(32'h1, 32'h0302, 32'h3);
        send_pkt(32'h1, 32'h0300, 32'h0);
        send_pkt(32'h1, 32'h0301, 32'h9);
        verify("R5");
        mark();
        draw();
        push(2, 16'h0301, 32'h9);
        push(2, 16'h0302, 32'h3);
        verify("R5");

        // R5 direct write to a tracked address updates the known value
        mark();
        send_pkt(32'h0, 32'h0301, 32'hA);
        send_pkt(32'h1, 32'h0301, 32'hA);
        draw();
        push(2, 16'h0301, 32'hA);
        verify("R5");

        // R7 / R8 binning hazard
        mark();
        send_pkt(32'h0, RENDER, 32'h4);
        bypass_mode = 1'b1;
        draw();
        send_pkt(32'h0, RENDER, 32'h0);
        push(2, RENDER, 32'h4);
        push(2, RENDER, 32'h0);
        verify("R7");
        mark();
        send_pkt(32'h2, RENDER, 32'h4);
        push(2, RENDER, 32'h4);
        verify("R7");
        mark();
        send_pkt(32'h6, RENDER, 32'h0);
        chk(first == 3'b100, "R7", 64'(first), 64'h4);
        push(1, '0, '0);
        push(2, RENDER, 32'h0);
        push(3, '0, 32'h3F);
        verify("R10");
        mark();
        draw();
        send_pkt(32'h2, RENDER, 32'h0);
        push(2, RENDER, 32'h0);
        verify("R8");
        mark();
        send_pkt(32'h0, RENDER, 32'h4);
        bypass_mode = 1'b0;
        draw();
        send_pkt(32'h2, RENDER, 32'h0);
        push(2, RENDER, 32'h4);
        push(2, RENDER, 32'h0);
        verify("R8");

        // R10 backpressure on the write channel
        @(posedge clk); #1;
        wr_ready = 1'b0;
        mark();
        send_pkt(32'h4, 32'h0050, 32'h0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(wr_valid && !evt_valid && wr_addr == 16'h0050, "R10",
                {62'h0, wr_valid, evt_valid}, 64'h2);
        end
        @(posedge clk); #1;
        wr_ready = 1'b1;
        push(2, 16'h0050, 32'h0);
        push(3, '0, 32'h3F);
        verify("R10");

        // R11 draw arrives during a packet
        mark();
        send_pkt(32'h1, 32'h0302, 32'h77);
        @(negedge clk);
        send_word(32'h0);
        send_word(32'h60);
        pkt_valid = 1'b1;
        pkt_word = 32'h99;
        draw_strobe = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
        draw_strobe = 1'b0;
        @(negedge clk);
        chk(!pkt_ready && !wr_valid, "R11", {62'h0, pkt_ready, wr_valid}, 64'h0);
        push(2, 16'h0060, 32'h99);
        push(2, 16'h0302, 32'h77);
        verify("R11");
        chk(pkt_ready, "R11", 64'(pkt_ready), 64'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule